// File: doc/BRIEF.md
# Unified GF(3^97) Add / Multiply / Cube Operator

This block is the arithmetic core of a small pairing coprocessor. It works in the field GF(3)[x]/(x^97 + x^12 + 2). Every element is 97 trits, and each trit takes two bits. One datapath does three jobs. It does a digit-serial multiply that takes three multiplier trits per clock. It does a one-cycle weighted sum of two operands, which covers add, subtract and doubling. It does a one-cycle cube.

All three operations share the same three partial-product generators, the same four-input adder and the same accumulator. Addition works by loading a constant digit pattern into the multiplier shift register. Cubing feeds three fixed rearrangements of the operand into the generators.

An external sequencer drives an 11-bit control word every cycle and supplies operands on two buses. The digit bus fills the 99-trit shift register. The operand bus fills the two parallel operand registers. The accumulator is the only output, and it can be fed back into either operand register so that cubes can be chained.

Top module: `gf3m_unified_op`

## Requirements
- R1: After reset, the accumulator reads zero.
- R2: Multiply sequence. Control bits 0, 2 and 4 load the shift register from the digit bus (multiplier zero-extended to 99 trits) and load both operand registers from the operand bus. Bit 1 shifts the shift register up by three trits, and bit 0 takes priority over it. The first iteration uses bits 1, 6 and 8 with bit 9 clear and leaves a96·b in the accumulator. Then 32 iterations with bit 9 also set leave a·b mod f, for 33 iterations in all.
- R3: Every result is reduced modulo x^97 + x^12 + 2, so x^97 is replaced by 2x^12 + 1. This holds up to the largest product, x^96·x^96.
- R4: Weighted sum. With bit 8 set and bits 6, 7 and 9 clear, one cycle gives acc = t96·R2 + t97·R1 + t98·R2, where t96, t97 and t98 are the shift-register trits at those positions. The pattern 2,1,0 repeated along the register gives b − a when a is in R2 and b is in R1.
- R5: Cube. With bits 7 and 8 set and all three top trits of the shift register equal to s, one cycle gives acc = s·R1^3. So s = 1 gives the cube and s = 2 gives its negation.
- R6: Feedback. Bit 3 (for R1, together with load bit 2) and bit 5 (for R2, together with load bit 4) take the register's new value from the accumulator instead of the operand bus. Without its load bit, R1 keeps its value. Two chained cubes of a give a^9.
- R7: With bit 8 clear and bit 10 clear, the accumulator keeps its value, even while registers are loaded.
- R8: Bit 10 clears the accumulator on the next edge and overrides bit 8.
- R9: Trits are encoded 00 = 0, 01 = 1, 10 = 2. Given legal inputs, the accumulator never holds a trit coded 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlWord | input | 11 | Per-cycle control bits, as assigned in the requirements |
| digitBus | input | 198 | 99-trit value for the multiplier shift register |
| operandBus | input | 194 | 97-trit value for R1 and R2 |
| accOut | output | 194 | Accumulator |

## Verification
The bench has its own model. It forms products by schoolbook multiplication followed by top-down reduction. It forms sums as trit-wise linear combinations.

Multiplication is run with several kinds of operands:
- random operands;
- all-twos operands, which stress every carry in the GF(3) adders;
- x^96·x^96, which drives the reduction to its highest degree;
- zero and one, which separate a wrong weight from a wrong reduction.

The weighted-sum patterns (2,1,0), (1,1,0) and (1,0,1) tell apart the three generator lanes and their operand routing. Cubes with weights 1 and 2, plus a fed-back second cube, exercise the permutation wiring and both return paths.

// File: rtl/gf3m_pkg.sv
package gf3m_pkg;

  // Strobes from the control decoder to the datapath.
  typedef struct packed {
    logic r0Load;
    logic r0Shift;
    logic r1Load;
    logic r1FromAcc;
    logic r2Load;
    logic r2FromAcc;
    logic ppgShift;
    logic cubeSel;
    logic accEn;
    logic accFold;
    logic accClr;
  } strobe_t;

  // GF(3) sum of two trits coded 00/01/10.
  function automatic logic [1:0] tritAdd(input logic [1:0] x, input logic [1:0] y);
    logic [2:0] s;
    s = {1'b0, x} + {1'b0, y};
    if (s >= 3'd3) s = s - 3'd3;
    return s[1:0];
  endfunction

  // GF(3) product of two trits.
  function automatic logic [1:0] tritMul(input logic [1:0] x, input logic [1:0] y);
    if (x == 2'd0 || y == 2'd0) return 2'd0;
    if (x == y) return 2'd1;
    return 2'd2;
  endfunction

endpackage

// File: rtl/gf3m_ctrl.sv
module gf3m_ctrl
  import gf3m_pkg::*;
(
  input  logic [10:0] ctrlWord,
  output strobe_t     strb
);

  always_comb begin
    strb.r0Load    = ctrlWord[0];
    strb.r0Shift   = ctrlWord[1] & ~ctrlWord[0];
    strb.r1Load    = ctrlWord[2];
    strb.r1FromAcc = ctrlWord[3];
    strb.r2Load    = ctrlWord[4];
    strb.r2FromAcc = ctrlWord[5];
    strb.ppgShift  = ctrlWord[6];
    strb.cubeSel   = ctrlWord[7];
    strb.accEn     = ctrlWord[8] & ~ctrlWord[10];
    strb.accFold   = ctrlWord[9];
    strb.accClr    = ctrlWord[10];
  end

endmodule

// File: rtl/gf3m_ppg.sv
module gf3m_ppg #(
  parameter int M     = 97,
  parameter int TAP   = 12,
  parameter int SHIFT = 0
) (
  input  logic [2*M-1:0] operand,
  input  logic [1:0]     digit,
  input  logic           shiftEn,
  output logic [2*M-1:0] pp
);
  localparam int W = 2 * M;

  function automatic logic [W-1:0] mulX(input logic [W-1:0] v);
    logic [W-1:0] r;
    logic [1:0]   hi;
    hi = v[W-1 -: 2];
    r  = {v[W-3:0], 2'b00};
    r[1:0] = hi;
    r[2*TAP +: 2] = gf3m_pkg::tritAdd(r[2*TAP +: 2], gf3m_pkg::tritMul(hi, 2'd2));
    return r;
  endfunction

  logic [W-1:0] shifted;

  always_comb begin
    shifted = operand;
    for (int s = 0; s < SHIFT; s++) begin
      if (shiftEn) shifted = mulX(shifted);
    end
    for (int t = 0; t < M; t++) begin
      pp[2*t +: 2] = gf3m_pkg::tritMul(shifted[2*t +: 2], digit);
    end
  end

endmodule

// File: rtl/gf3m_frob.sv
module gf3m_frob #(
  parameter int M   = 97,
  parameter int TAP = 12,
  parameter int D   = 3
) (
  input  logic [2*M-1:0]        src,
  output logic [D-1:0][2*M-1:0] nu
);
  localparam int W    = 2 * M;
  localparam int SPAN = (M + D - 1) / D;
  localparam int CHAR = 3;

  function automatic logic [W-1:0] mulX(input logic [W-1:0] v);
    logic [W-1:0] r;
    logic [1:0]   hi;
    hi = v[W-1 -: 2];
    r  = {v[W-3:0], 2'b00};
    r[1:0] = hi;
    r[2*TAP +: 2] = gf3m_pkg::tritAdd(r[2*TAP +: 2], gf3m_pkg::tritMul(hi, 2'd2));
    return r;
  endfunction

  function automatic logic [W-1:0] addScaled(input logic [W-1:0] acc,
                                             input logic [W-1:0] v,
                                             input logic [1:0]   k);
    logic [W-1:0] r;
    for (int t = 0; t < M; t++) begin
      r[2*t +: 2] = gf3m_pkg::tritAdd(acc[2*t +: 2], gf3m_pkg::tritMul(v[2*t +: 2], k));
    end
    return r;
  endfunction

  logic [W-1:0] basis;

  // a^3 = sum a_i * (x^(3i) mod f); the terms are split into D groups,
  // one per partial-product lane. Constant basis vectors fold into wiring.
  always_comb begin
    nu    = '0;
    basis = {{(W-2){1'b0}}, 2'b01};
    for (int i = 0; i < M; i++) begin
      nu[i / SPAN] = addScaled(nu[i / SPAN], basis, src[2*i +: 2]);
      for (int s = 0; s < CHAR; s++) basis = mulX(basis);
    end
  end

endmodule

// File: rtl/gf3m_datapath.sv
module gf3m_datapath
  import gf3m_pkg::*;
#(
  parameter int M   = 97,
  parameter int TAP = 12,
  parameter int D   = 3
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  strobe_t                          strb,
  input  logic [2*D*((M+D-1)/D)-1:0]       digitBus,
  input  logic [2*M-1:0]                   operandBus,
  output logic [2*M-1:0]                   accOut
);
  localparam int W    = 2 * M;
  localparam int ITER = (M + D - 1) / D;
  localparam int NR0  = D * ITER;
  localparam int WR0  = 2 * NR0;
  localparam logic [W-1:0] EVEN_BITS = {M{2'b01}};

  function automatic logic [W-1:0] mulX(input logic [W-1:0] v);
    logic [W-1:0] r;
    logic [1:0]   hi;
    hi = v[W-1 -: 2];
    r  = {v[W-3:0], 2'b00};
    r[1:0] = hi;
    r[2*TAP +: 2] = tritAdd(r[2*TAP +: 2], tritMul(hi, 2'd2));
    return r;
  endfunction

  function automatic logic [W-1:0] vecAdd(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W-1:0] r;
    for (int t = 0; t < M; t++) r[2*t +: 2] = tritAdd(x[2*t +: 2], y[2*t +: 2]);
    return r;
  endfunction

  logic [WR0-1:0]      r0q;
  logic [W-1:0]        r1q, r2q, accq;
  logic [D-1:0][W-1:0] nu;
  logic [D-1:0][W-1:0] opSel;
  logic [D-1:0][W-1:0] pp;
  logic [W-1:0]        foldTerm, nextSum;

  gf3m_frob #(.M(M), .TAP(TAP), .D(D)) u_frob (
    .src (r1q),
    .nu  (nu)
  );

  for (genvar k = 0; k < D; k++) begin : g_lane
    localparam bit USE_R1 = (k % 2) == 1;
    assign opSel[k] = strb.cubeSel ? nu[k] : (USE_R1 ? r1q : r2q);
    gf3m_ppg #(.M(M), .TAP(TAP), .SHIFT(k)) u_ppg (
      .operand (opSel[k]),
      .digit   (r0q[2*(NR0-D+k) +: 2]),
      .shiftEn (strb.ppgShift),
      .pp      (pp[k])
    );
  end

  always_comb begin
    foldTerm = accq;
    for (int s = 0; s < D; s++) foldTerm = mulX(foldTerm);
    nextSum = strb.accFold ? foldTerm : '0;
    for (int k = 0; k < D; k++) nextSum = vecAdd(nextSum, pp[k]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      r0q  <= '0;
      r1q  <= '0;
      r2q  <= '0;
      accq <= '0;
    end else begin
      if (strb.r0Load)       r0q <= digitBus;
      else if (strb.r0Shift) r0q <= r0q << (2*D);
      if (strb.r1Load) r1q <= strb.r1FromAcc ? accq : operandBus;
      if (strb.r2Load) r2q <= strb.r2FromAcc ? accq : operandBus;
      if (strb.accClr)     accq <= '0;
      else if (strb.accEn) accq <= nextSum;
    end
  end

  assign accOut = accq;

  assert_acc_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.accEn && !strb.accClr) |=> $stable(accq));

  assert_acc_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.accClr |=> (accq == '0));

  assert_r1_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.r1Load |=> $stable(r1q));

  assert_trits_legal_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((accq >> 1) & accq & EVEN_BITS) == '0);

endmodule

// File: rtl/gf3m_unified_op.sv
module gf3m_unified_op
  import gf3m_pkg::*;
#(
  parameter int M   = 97,
  parameter int TAP = 12,
  parameter int D   = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [10:0]                ctrlWord,
  input  logic [2*D*((M+D-1)/D)-1:0] digitBus,
  input  logic [2*M-1:0]             operandBus,
  output logic [2*M-1:0]             accOut
);

  strobe_t strb;

  gf3m_ctrl u_ctrl (
    .ctrlWord (ctrlWord),
    .strb     (strb)
  );

  gf3m_datapath #(.M(M), .TAP(TAP), .D(D)) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .digitBus   (digitBus),
    .operandBus (operandBus),
    .accOut     (accOut)
  );

endmodule

// File: tb/test_gf3m_unified_op.sv
`timescale 1ns/1ps
module test_gf3m_unified_op;
  localparam int M    = 97;
  localparam int TAP  = 12;
  localparam int D    = 3;
  localparam int ITER = (M + D - 1) / D;
  localparam int W    = 2 * M;
  localparam int WR0  = 2 * D * ITER;

  localparam logic [10:0] R0LD = 11'd1 << 0;
  localparam logic [10:0] R0SH = 11'd1 << 1;
  localparam logic [10:0] R1LD = 11'd1 << 2;
  localparam logic [10:0] R1AC = 11'd1 << 3;
  localparam logic [10:0] R2LD = 11'd1 << 4;
  localparam logic [10:0] R2AC = 11'd1 << 5;
  localparam logic [10:0] PSH  = 11'd1 << 6;
  localparam logic [10:0] CUBE = 11'd1 << 7;
  localparam logic [10:0] EN   = 11'd1 << 8;
  localparam logic [10:0] FOLD = 11'd1 << 9;
  localparam logic [10:0] CLR  = 11'd1 << 10;

  logic           clk = 1'b0;
  logic           rstN;
  logic [10:0]    ctrlWord;
  logic [WR0-1:0] digitBus;
  logic [W-1:0]   operandBus;
  logic [W-1:0]   accOut;

  int nChecks = 0;
  int nErrors = 0;
  int unsigned rngState = 32'h1234_abcd;

  always #10 clk = ~clk;

  gf3m_unified_op i_gf3m_unified_op (
    .clk(clk), .rstN(rstN), .ctrlWord(ctrlWord),
    .digitBus(digitBus), .operandBus(operandBus), .accOut(accOut)
  );

  function automatic int unsigned nextRand();
    rngState ^= rngState << 13;
    rngState ^= rngState >> 17;
    rngState ^= rngState << 5;
    return rngState;
  endfunction

  function automatic logic [W-1:0] randElem();
    logic [W-1:0] v;
    for (int t = 0; t < M; t++) v[2*t +: 2] = 2'(nextRand() % 3);
    return v;
  endfunction

  function automatic logic [W-1:0] refMul(input logic [W-1:0] a, input logic [W-1:0] b);
    int prod [2*M];
    logic [W-1:0] r;
    for (int k = 0; k < 2*M; k++) prod[k] = 0;
    for (int i = 0; i < M; i++)
      for (int j = 0; j < M; j++)
        prod[i+j] = (prod[i+j] + int'(a[2*i +: 2]) * int'(b[2*j +: 2])) % 3;
    for (int k = 2*M-2; k >= M; k--) begin
      int c;
      c = prod[k];
      prod[k] = 0;
      prod[k-M] = (prod[k-M] + c) % 3;
      prod[k-M+TAP] = (prod[k-M+TAP] + 2*c) % 3;
    end
    for (int k = 0; k < M; k++) r[2*k +: 2] = 2'(prod[k]);
    return r;
  endfunction

  function automatic logic [W-1:0] refLin(input int wa, input logic [W-1:0] a,
                                          input int wb, input logic [W-1:0] b);
    logic [W-1:0] r;
    for (int k = 0; k < M; k++)
      r[2*k +: 2] = 2'((wa * int'(a[2*k +: 2]) + wb * int'(b[2*k +: 2])) % 3);
    return r;
  endfunction

  function automatic logic [WR0-1:0] pattern(input logic [1:0] d0, input logic [1:0] d1,
                                             input logic [1:0] d2);
    logic [WR0-1:0] r;
    for (int i = 0; i < ITER; i++) begin
      r[2*(3*i) +: 2]   = d0;
      r[2*(3*i+1) +: 2] = d1;
      r[2*(3*i+2) +: 2] = d2;
    end
    return r;
  endfunction

  function automatic logic [W-1:0] monomial(input int e);
    logic [W-1:0] r;
    r = '0;
    r[2*e +: 2] = 2'd1;
    return r;
  endfunction

  function automatic bit isLegal(input logic [W-1:0] v);
    for (int t = 0; t < M; t++) if (v[2*t +: 2] == 2'b11) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    nChecks++;
    if (got !== exp) begin
      nErrors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step(input logic [10:0] cw, input logic [WR0-1:0] da, input logic [W-1:0] ob);
    ctrlWord   = cw;
    digitBus   = da;
    operandBus = ob;
    @(negedge clk);
    ctrlWord = '0;
  endtask

  task automatic doMul(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    step(R0LD | R1LD | R2LD, {{(WR0-W){1'b0}}, a}, b);
    step(R0SH | PSH | EN, '0, '0);
    check({"R2 first iteration ", tag}, accOut, refLin(int'(a[2*(M-1) +: 2]), b, 0, b));
    for (int i = 1; i < ITER; i++) step(R0SH | PSH | EN | FOLD, '0, '0);
    check({"R2 R3 product ", tag}, accOut, refMul(a, b));
  endtask

  task automatic doWeighted(input logic [W-1:0] a, input logic [W-1:0] b,
                            input logic [1:0] d0, input logic [1:0] d1, input logic [1:0] d2,
                            input string tag);
    step(R2LD, '0, a);
    step(R1LD | R0LD, pattern(d0, d1, d2), b);
    step(EN, '0, '0);
    check({"R4 weighted sum ", tag}, accOut, refLin(int'(d0) + int'(d2), a, int'(d1), b));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog: run did not complete");
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  initial begin
    logic [W-1:0] a, b, cube, held, allTwo;
    rstN = 1'b0; ctrlWord = '0; digitBus = '0; operandBus = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset accumulator", accOut, '0);

    // R2 / R3: multiply with several operand kinds
    for (int n = 0; n < 3; n++) begin
      a = randElem(); b = randElem();
      doMul(a, b, "random");
    end
    doMul(monomial(M-1), monomial(M-1), "x96*x96");
    allTwo = '0;
    for (int t = 0; t < M; t++) allTwo[2*t +: 2] = 2'd2;
    doMul(allTwo, allTwo, "all twos");
    doMul('0, randElem(), "zero multiplier");
    doMul(monomial(0), randElem(), "unit multiplier");

    // R4: weighted sums
    a = randElem(); b = randElem();
    doWeighted(a, b, 2'd2, 2'd1, 2'd0, "b-a");
    doWeighted(a, b, 2'd1, 2'd1, 2'd0, "a+b");
    doWeighted(a, b, 2'd1, 2'd0, 2'd1, "2a");

    // R5: cube and negated cube
    a = randElem();
    cube = refMul(refMul(a, a), a);
    step(R0LD | R1LD, pattern(2'd2, 2'd2, 2'd2), a);
    step(CUBE | EN, '0, '0);
    check("R5 negated cube", accOut, refLin(2, cube, 0, cube));
    step(R0LD, pattern(2'd1, 2'd1, 2'd1), '0);
    step(CUBE | EN, '0, '0);
    check("R5 cube", accOut, cube);

    // R6: feed the cube back into R1 and cube again -> a^9
    step(R1LD | R1AC, '0, randElem());
    step(CUBE | EN, '0, '0);
    held = refMul(refMul(cube, cube), cube);
    check("R6 chained cube via R1", accOut, held);
    // R6: copy accumulator into R2, pass through lane 0 with weight 1
    step(R2LD | R2AC | R0LD, pattern(2'd1, 2'd0, 2'd0), randElem());
    step(EN, '0, '0);
    check("R6 accumulator routed through R2", accOut, held);

    // R7: loads without accumulate leave the result unchanged
    step(R0LD | R1LD | R2LD, pattern(2'd1, 2'd2, 2'd1), randElem());
    step(PSH | FOLD, '0, '0);
    check("R7 accumulator hold", accOut, held);

    // R8: clear overrides accumulate
    step(CLR | EN | FOLD, '0, '0);
    check("R8 clear over enable", accOut, '0);

    // R9: legal trit codes after a mixed-sign product
    doMul(allTwo, randElem(), "legality operand");
    nChecks++;
    if (!isLegal(accOut)) begin
      nErrors++;
      $display("FAIL R9 illegal trit code in %h expected none coded 11", accOut);
    end

    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

endmodule